// File: doc/BRIEF.md
# Accumulator Execution Datapath

This block is the execution half of a small 8-bit accumulator machine. A separate sequencer presents one control word per clock. The word chooses what the accumulator loads, which register-file entry is read or written, which ALU operation runs, which shift follows it, and whether the accumulator is driven out. The datapath holds eight 8-bit general registers and one accumulator. It has no instruction storage and no decoder of its own.

The ALU always takes the accumulator as its first operand. Its second operand is the register-file entry named by the register address. The ALU result then passes through a shifter before it reaches the accumulator source selector. The selector's other three inputs are register read data, the external data input, and an immediate byte. The accumulator drives two status flags, zero and positive, which the sequencer uses for conditional decisions.

Top module: `acc_datapath`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, all register-file entries and the data output. After release, zero_flag is 1 and pos_flag is 0.
- R2: When reg_we is high at a clock edge, the accumulator value from before that edge is written to the entry at reg_addr. With acc_we high and src_sel = 01, the accumulator loads the entry at reg_addr.
- R3: With acc_we high, src_sel = 10 loads din and src_sel = 11 loads imm.
- R4: With src_sel = 00, the two-operand ALU codes combine the accumulator (first operand) with the entry at reg_addr (second operand): 001 AND, 010 OR, 100 ADD, 101 accumulator minus entry. ADD and subtract wrap modulo 256.
- R5: The single-operand ALU codes act on the accumulator alone: 000 pass, 011 bitwise NOT, 110 increment, 111 decrement. Increment and decrement wrap modulo 256.
- R6: The shifter acts on the ALU result: shift_op 00 pass, 01 shift left with a 0 into bit 0, 10 shift right with a 0 into bit 7, 11 rotate right with bit 0 moving to bit 7.
- R7: While acc_we is low, the accumulator keeps its value whatever src_sel, imm, din or the ALU controls are.
- R8: zero_flag is 1 exactly when the accumulator is 0. pos_flag is 1 exactly when the accumulator is nonzero and its bit 7 is 0. Both follow the accumulator without delay.
- R9: dout is a register. At an edge with out_en high it takes the accumulator value from before that edge. At an edge with out_en low it becomes 0.
- R10: If reg_we and acc_we (src_sel = 01, same address) are both high at one edge, the entry receives the old accumulator and the accumulator receives the old entry, so the two values swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | External data input (src_sel 10) |
| imm | input | 8 | Immediate byte (src_sel 11) |
| src_sel | input | 2 | Accumulator source select |
| acc_we | input | 1 | Accumulator load enable |
| reg_addr | input | 3 | Register-file entry for read and write |
| reg_we | input | 1 | Register-file write enable (data = accumulator) |
| alu_op | input | 3 | ALU operation code |
| shift_op | input | 2 | Shift operation code |
| out_en | input | 1 | Drive accumulator on dout at next edge |
| dout | output | 8 | Registered data output |
| zero_flag | output | 1 | Accumulator is zero |
| pos_flag | output | 1 | Accumulator is nonzero with bit 7 clear |

## Verification
The bench sweeps every accumulator value through each single-operand and shift code. It covers the edge bits: a shifter that keeps bit 7 on a right shift, or drops bit 0 on a rotate, shows up at 0x01 and 0x80. Two-operand operations run over a grid of operand pairs that includes 0x00, 0x7F, 0x80 and 0xFF, so missing wraparound or swapped subtract operands produce wrong sums. The bench also checks the swap of R10, which breaks if the register write takes the new accumulator value. It checks the flags at 0x00, 0x7F and 0x80, where a flag based on sign alone, or one that counts zero as positive, gives the wrong answer.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

  localparam int SRC_W   = 2;
  localparam int ALU_W   = 3;
  localparam int SHIFT_W = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_CHAIN = 2'b00,
    SRC_REG   = 2'b01,
    SRC_DIN   = 2'b10,
    SRC_IMM   = 2'b11
  } src_sel_e;

  typedef enum logic [ALU_W-1:0] {
    ALU_PASS = 3'b000,
    ALU_AND  = 3'b001,
    ALU_OR   = 3'b010,
    ALU_NOT  = 3'b011,
    ALU_ADD  = 3'b100,
    ALU_SUB  = 3'b101,
    ALU_INC  = 3'b110,
    ALU_DEC  = 3'b111
  } alu_op_e;

  typedef enum logic [SHIFT_W-1:0] {
    SH_PASS = 2'b00,
    SH_LEFT = 2'b01,
    SH_RGHT = 2'b10,
    SH_ROTR = 2'b11
  } shift_op_e;

endpackage

// File: rtl/acc_regfile.sv
module acc_regfile #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] entry_q [DEPTH];

  // One register per entry so that reset can clear the whole file in one edge.
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        entry_q[g] <= '0;
      end else if (we && (addr == AW'(g))) begin
        entry_q[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (addr == AW'(i)) rdata = entry_q[i];
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_dp_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] res
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (op)
      ALU_PASS: res = acc;
      ALU_AND:  res = acc & opnd;
      ALU_OR:   res = acc | opnd;
      ALU_NOT:  res = ~acc;
      ALU_ADD:  res = acc + opnd;
      ALU_SUB:  res = acc - opnd;
      ALU_INC:  res = acc + ONE;
      ALU_DEC:  res = acc - ONE;
      default:  res = acc;
    endcase
  end

endmodule

// File: rtl/acc_shifter.sv
module acc_shifter
  import acc_dp_pkg::*;
#(
  parameter int W = 8
) (
  input  shift_op_e    op,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  always_comb begin
    unique case (op)
      SH_PASS: dout = din;
      SH_LEFT: dout = {din[W-2:0], 1'b0};
      SH_RGHT: dout = {1'b0, din[W-1:1]};
      SH_ROTR: dout = {din[0], din[W-1:1]};
      default: dout = din;
    endcase
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_dp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8,
  localparam int AW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  din,
  input  logic [DATA_W-1:0]  imm,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic               acc_we,
  input  logic [AW-1:0]      reg_addr,
  input  logic               reg_we,
  input  logic [ALU_W-1:0]   alu_op,
  input  logic [SHIFT_W-1:0] shift_op,
  input  logic               out_en,
  output logic [DATA_W-1:0]  dout,
  output logic               zero_flag,
  output logic               pos_flag
);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] rf_rdata;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] chain_res;
  logic [DATA_W-1:0] acc_next;
  logic [DATA_W-1:0] dout_q;

  acc_regfile #(.W(DATA_W), .DEPTH(NUM_REGS)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (acc_q),
    .rdata (rf_rdata)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .op   (alu_op_e'(alu_op)),
    .acc  (acc_q),
    .opnd (rf_rdata),
    .res  (alu_res)
  );

  acc_shifter #(.W(DATA_W)) u_shift (
    .op   (shift_op_e'(shift_op)),
    .din  (alu_res),
    .dout (chain_res)
  );

  always_comb begin
    unique case (src_sel_e'(src_sel))
      SRC_CHAIN: acc_next = chain_res;
      SRC_REG:   acc_next = rf_rdata;
      SRC_DIN:   acc_next = din;
      SRC_IMM:   acc_next = imm;
      default:   acc_next = chain_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (acc_we) begin
      acc_q <= acc_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
    end else begin
      dout_q <= out_en ? acc_q : '0;
    end
  end

  assign dout      = dout_q;
  assign zero_flag = (acc_q == '0);
  assign pos_flag  = (acc_q != '0) && !acc_q[DATA_W-1];

endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] din,
  input logic [W-1:0] imm,
  input logic [1:0]   src_sel,
  input logic         acc_we,
  input logic         out_en,
  input logic [W-1:0] dout,
  input logic         zero_flag,
  input logic         pos_flag,
  input logic [W-1:0] acc_q
);

  AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (zero_flag && !pos_flag && dout == '0));           // R1

  AST_IMM_LOAD: assert property (@(posedge clk) disable iff (rst)
    (acc_we && src_sel == 2'b11) |=> (acc_q == $past(imm)));          // R3

  AST_DIN_LOAD: assert property (@(posedge clk) disable iff (rst)
    (acc_we && src_sel == 2'b10) |=> (acc_q == $past(din)));          // R3

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_we |=> $stable(acc_q));                                      // R7

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(zero_flag && pos_flag));                                        // R8

  AST_OUT_DRIVE: assert property (@(posedge clk) disable iff (rst)
    out_en |=> (dout == $past(acc_q)));                               // R9

  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (dout == '0));                                        // R9

endmodule

bind acc_datapath acc_datapath_chk #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .din       (din),
  .imm       (imm),
  .src_sel   (src_sel),
  .acc_we    (acc_we),
  .out_en    (out_en),
  .dout      (dout),
  .zero_flag (zero_flag),
  .pos_flag  (pos_flag),
  .acc_q     (acc_q)
);

// File: tb/acc_datapath_tb.sv
module acc_datapath_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [W-1:0]  din;
  logic [W-1:0]  imm;
  logic [1:0]    src_sel;
  logic          acc_we;
  logic [AW-1:0] reg_addr;
  logic          reg_we;
  logic [2:0]    alu_op;
  logic [1:0]    shift_op;
  logic          out_en;
  logic [W-1:0]  dout;
  logic          zero_flag;
  logic          pos_flag;

  int vectors = 0;
  int fails   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_datapath u_dut (
    .clk(clk), .rst(rst), .din(din), .imm(imm), .src_sel(src_sel),
    .acc_we(acc_we), .reg_addr(reg_addr), .reg_we(reg_we), .alu_op(alu_op),
    .shift_op(shift_op), .out_en(out_en), .dout(dout),
    .zero_flag(zero_flag), .pos_flag(pos_flag)
  );

  function automatic logic [W-1:0] alu_ref(input logic [2:0] op, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    int r;
    case (op)
      3'b001:  r = a & b;
      3'b010:  r = a | b;
      3'b011:  r = 255 - a;
      3'b100:  r = (a + b) % 256;
      3'b101:  r = (a - b + 256) % 256;
      3'b110:  r = (a + 1) % 256;
      3'b111:  r = (a + 255) % 256;
      default: r = a;
    endcase
    return W'(r);
  endfunction

  function automatic logic [W-1:0] shift_ref(input logic [1:0] op, input logic [W-1:0] a);
    int r;
    case (op)
      2'b01:   r = (a * 2) % 256;
      2'b10:   r = a / 2;
      2'b11:   r = a / 2 + (a % 2) * 128;
      default: r = a;
    endcase
    return W'(r);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    src_sel = 2'b00; acc_we = 1'b0; reg_we = 1'b0;
    alu_op = 3'b000; shift_op = 2'b00; out_en = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_imm(input logic [W-1:0] v);
    idle(); src_sel = 2'b11; imm = v; acc_we = 1'b1; tick(); idle();
  endtask

  task automatic store(input logic [AW-1:0] a);
    idle(); reg_addr = a; reg_we = 1'b1; tick(); idle();
  endtask

  task automatic load_reg(input logic [AW-1:0] a);
    idle(); reg_addr = a; src_sel = 2'b01; acc_we = 1'b1; tick(); idle();
  endtask

  task automatic run_op(input logic [2:0] op, input logic [1:0] sh, input logic [AW-1:0] a);
    idle(); alu_op = op; shift_op = sh; reg_addr = a; acc_we = 1'b1; tick(); idle();
  endtask

  // Reads the accumulator through dout and checks the flags against it.
  task automatic check_acc(input string req, input logic [W-1:0] exp);
    idle(); out_en = 1'b1; tick(); idle();
    chk(req, dout, exp);
    chk({req, " zero_flag (R8)"}, zero_flag, exp == 0);
    chk({req, " pos_flag (R8)"}, pos_flag, (exp != 0) && (exp < 128));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] bvals [8];
    bvals = '{8'h00, 8'h01, 8'h0F, 8'h55, 8'h7F, 8'h80, 8'hAA, 8'hFF};
    rst = 1'b1; din = '0; imm = '0; reg_addr = '0; idle();
    repeat (3) tick();
    rst = 1'b0;
    chk("R1 dout after reset", dout, 0);
    chk("R1 zero_flag after reset", zero_flag, 1);
    chk("R1 pos_flag after reset", pos_flag, 0);

    // R2: write distinct values into every entry, read them back
    for (int i = 0; i < 8; i++) begin
      load_imm(W'(8'h11 * (i + 1))); store(AW'(i));
    end
    for (int i = 0; i < 8; i++) begin
      load_reg(AW'(i)); check_acc("R2 register readback", W'(8'h11 * (i + 1)));
    end

    // R1: mid-run reset clears the register file
    rst = 1'b1; tick(); rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      load_imm(8'hEE); load_reg(AW'(i)); check_acc("R1 register cleared", 8'h00);
    end

    // R3: external input and immediate sources
    for (int v = 0; v < 256; v += 37) begin
      idle(); din = W'(v); src_sel = 2'b10; acc_we = 1'b1; tick(); idle();
      check_acc("R3 din load", W'(v));
      load_imm(W'(255 - v)); check_acc("R3 imm load", W'(255 - v));
    end

    // R4: two-operand operations over an operand grid
    for (int bi = 0; bi < 8; bi++) begin
      load_imm(bvals[bi]); store(AW'(bi));
      for (int a = 0; a < 256; a += 5) begin
        for (int k = 0; k < 4; k++) begin
          logic [2:0] op;
          op = (k == 0) ? 3'b001 : (k == 1) ? 3'b010 : (k == 2) ? 3'b100 : 3'b101;
          load_imm(W'(a)); run_op(op, 2'b00, AW'(bi));
          check_acc("R4 two-operand ALU", alu_ref(op, W'(a), bvals[bi]));
        end
      end
    end

    // R5 and R6: every accumulator value through single-operand and shift codes
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 4; k++) begin
        logic [2:0] op;
        op = (k == 0) ? 3'b000 : (k == 1) ? 3'b011 : (k == 2) ? 3'b110 : 3'b111;
        load_imm(W'(a)); run_op(op, 2'b00, AW'(0));
        check_acc("R5 single-operand ALU", alu_ref(op, W'(a), 8'h00));
      end
      for (int s = 1; s < 4; s++) begin
        load_imm(W'(a)); run_op(3'b000, 2'(s), AW'(0));
        check_acc("R6 shifter", shift_ref(2'(s), W'(a)));
      end
    end
    // R6: shift applied after an ALU result
    load_imm(8'h80); run_op(3'b110, 2'b11, AW'(0));
    check_acc("R6 increment then rotate", 8'hC0);

    // R7: accumulator holds while acc_we is low
    load_imm(8'h3C);
    idle(); src_sel = 2'b11; imm = 8'hC3; din = 8'h99; alu_op = 3'b011; tick(); idle();
    check_acc("R7 hold with imm offered", 8'h3C);
    idle(); src_sel = 2'b10; tick(); idle();
    check_acc("R7 hold with din offered", 8'h3C);

    // R8: flag boundaries
    load_imm(8'h00); chk("R8 zero at 00", zero_flag, 1); chk("R8 pos at 00", pos_flag, 0);
    load_imm(8'h7F); chk("R8 zero at 7F", zero_flag, 0); chk("R8 pos at 7F", pos_flag, 1);
    load_imm(8'h80); chk("R8 zero at 80", zero_flag, 0); chk("R8 pos at 80", pos_flag, 0);

    // R9: dout returns to zero when out_en drops
    load_imm(8'h5A); check_acc("R9 dout driven", 8'h5A);
    tick(); chk("R9 dout idle zero", dout, 0);
    idle(); out_en = 1'b1; acc_we = 1'b1; src_sel = 2'b11; imm = 8'h21; tick(); idle();
    chk("R9 dout shows pre-edge acc", dout, 8'h5A);

    // R10: simultaneous register and accumulator write swaps values
    load_imm(8'hB4); store(AW'(5));
    load_imm(8'h4B);
    idle(); reg_addr = AW'(5); reg_we = 1'b1; acc_we = 1'b1; src_sel = 2'b01; tick(); idle();
    check_acc("R10 acc after swap", 8'hB4);
    load_reg(AW'(5)); check_acc("R10 entry after swap", 8'h4B);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule